// File: doc/BRIEF.md
# Byte-Lane Write Decoder with Registered Data Path

This block turns the write controls of a 32-bit synchronous SRAM port into one registered write strobe per byte lane. Three inputs settle each cycle, in order of priority. An address strobe from the processor, when low, turns the cycle into a read. Otherwise a global write, when low, writes every lane. Otherwise a byte-write gate, when low, passes the per-lane selects through. When no lane is chosen, the cycle is a read.

The strobes, the write data and the word address are captured together on the same rising edge. On the next edge the chosen lanes of a small byte-masked memory array are updated at that address. Whenever any strobe is active, the block also raises a registered signal that tells the pad logic to release the data bus.

The address is taken as given each cycle, normally from a burst sequencer outside this block. Read data comes from a registered read port on the same array.

Top module: `byte_write_ctrl`

## Requirements
- R1: While `rst` is high on a rising edge, `lane_strobe` and `drive_off` are both 0 after that edge.
- R2: When `proc_start_n` is high and `wr_all_n` is low at an edge, `lane_strobe` is 4'b1111 after that edge, whatever `lane_gate_n` and `lane_pick_n` are.
- R3: When `proc_start_n` and `wr_all_n` are high and `lane_gate_n` is low, `lane_strobe[i]` after the edge is the inverse of `lane_pick_n[i]`. Lane i covers data bits 8i+7 down to 8i, and any mix of lanes may be written in one cycle.
- R4: When `wr_all_n` and `lane_gate_n` are both high, `lane_pick_n` is ignored: no strobe is raised and the array is left unchanged.
- R5: When `lane_gate_n` is low but all of `lane_pick_n` are high (and `wr_all_n` is high), no lane is written.
- R6: When `proc_start_n` is low at an edge, no strobe is raised after it, even if `wr_all_n` is low, and the array is left unchanged.
- R7: `drive_off` is high after an edge exactly when at least one strobe is active after that edge.
- R8: `wr_data` and `word_addr` are registered on the same edge as the strobes. On the following edge, each strobed lane of the array at that address takes the matching byte of the registered data, and unstrobed lanes keep their contents.
- R9: `rd_data` shows the array contents at the registered address. The array is read before that edge's write, so a word read is issued at edge k and valid after edge k+1.
- R10: The address is used exactly as supplied in each cycle, so consecutive writes to changing addresses each land at their own word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_all_n | input | 1 | Global write, active low, writes all lanes |
| lane_gate_n | input | 1 | Byte-write gate, active low, enables the lane selects |
| lane_pick_n | input | 4 | Per-lane write selects, active low |
| proc_start_n | input | 1 | Processor address strobe, active low, blocks writes |
| word_addr | input | 6 | Word address for this cycle |
| wr_data | input | 32 | Write data |
| lane_strobe | output | 4 | Registered per-lane write strobes |
| drive_off | output | 1 | Registered request to release the data outputs |
| rd_data | output | 32 | Registered read data |

## Verification
The embedded properties assume that every control input is a clean 0 or 1 at each rising edge. They also assume reset is held for at least one edge before any write is judged. The bench changes every input only on the falling clock edge and releases reset only after several edges. The memory model marks every byte unknown until a write has landed, and compares read data only for bytes the bench has written. This means no check depends on the array's power-up contents.

// File: rtl/bwc_pkg.sv
package bwc_pkg;
  parameter int unsigned LANE_BITS = 8;
  parameter int unsigned LANE_COUNT = 4;
  parameter int unsigned WORD_ADDR_BITS = 6;

  typedef enum logic [1:0] {
    CYC_READ    = 2'd0,
    CYC_BLOCKED = 2'd1,
    CYC_GLOBAL  = 2'd2,
    CYC_BYTES   = 2'd3
  } cyc_kind_t;

  typedef struct packed {
    logic proc_n;
    logic all_n;
    logic gate_n;
  } wctl_t;
endpackage

// File: rtl/bwc_decode.sv
module bwc_decode #(
  parameter int unsigned LANES = bwc_pkg::LANE_COUNT
) (
  input  logic                clk,
  input  logic                rst,
  input  bwc_pkg::wctl_t      ctl,
  input  logic [LANES-1:0]    pick_n,
  output logic [LANES-1:0]    strobe,
  output logic                drive_off
);
  import bwc_pkg::*;

  cyc_kind_t        kind;
  logic [LANES-1:0] nxt;

  // priority: processor strobe blocks, then global write, then gated selects
  always_comb begin
    if (!ctl.proc_n)      kind = CYC_BLOCKED;
    else if (!ctl.all_n)  kind = CYC_GLOBAL;
    else if (!ctl.gate_n) kind = CYC_BYTES;
    else                  kind = CYC_READ;
  end

  always_comb begin
    case (kind)
      CYC_GLOBAL: nxt = {LANES{1'b1}};
      CYC_BYTES:  nxt = ~pick_n;
      default:    nxt = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      strobe    <= '0;
      drive_off <= 1'b0;
    end else begin
      strobe    <= nxt;
      drive_off <= |nxt;
    end
  end

  assert_global_all_R2: assert property (@(posedge clk) disable iff (rst)
    (ctl.proc_n && !ctl.all_n) |=> (strobe == {LANES{1'b1}}));

  assert_gated_lanes_R3: assert property (@(posedge clk) disable iff (rst)
    (ctl.proc_n && ctl.all_n && !ctl.gate_n) |=> (strobe == ~$past(pick_n)));

  assert_selects_ignored_R4: assert property (@(posedge clk) disable iff (rst)
    (ctl.all_n && ctl.gate_n) |=> (strobe == '0));

  assert_proc_blocks_R6: assert property (@(posedge clk) disable iff (rst)
    (!ctl.proc_n) |=> (strobe == '0 && !drive_off));

  assert_release_on_write_R7: assert property (@(posedge clk) disable iff (rst)
    (ctl.proc_n && !ctl.all_n) |=> drive_off);
endmodule

// File: rtl/bwc_datain.sv
module bwc_datain #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = bwc_pkg::WORD_ADDR_BITS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [DATA_W-1:0] data_in,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] data_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
      data_q <= '0;
    end else begin
      addr_q <= addr_in;
      data_q <= data_in;
    end
  end

  assert_addr_captured_R10: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (addr_q == $past(addr_in)));
endmodule

// File: rtl/bwc_lane_mem.sv
module bwc_lane_mem #(
  parameter int unsigned LANES  = bwc_pkg::LANE_COUNT,
  parameter int unsigned LANE_W = bwc_pkg::LANE_BITS,
  parameter int unsigned ADDR_W = bwc_pkg::WORD_ADDR_BITS,
  localparam int unsigned DATA_W = LANES * LANE_W,
  localparam int unsigned DEPTH  = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic [LANES-1:0]  we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] bank [DEPTH];
    always_ff @(posedge clk) begin
      if (we[g]) bank[addr] <= wdata[g*LANE_W +: LANE_W];
      rdata[g*LANE_W +: LANE_W] <= bank[addr];
    end
  end
endmodule

// File: rtl/byte_write_ctrl.sv
module byte_write_ctrl #(
  parameter int unsigned LANES  = bwc_pkg::LANE_COUNT,
  parameter int unsigned LANE_W = bwc_pkg::LANE_BITS,
  parameter int unsigned ADDR_W = bwc_pkg::WORD_ADDR_BITS,
  localparam int unsigned DATA_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_all_n,
  input  logic              lane_gate_n,
  input  logic [LANES-1:0]  lane_pick_n,
  input  logic              proc_start_n,
  input  logic [ADDR_W-1:0] word_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [LANES-1:0]  lane_strobe,
  output logic              drive_off,
  output logic [DATA_W-1:0] rd_data
);
  bwc_pkg::wctl_t    ctl;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;

  assign ctl = '{proc_n: proc_start_n, all_n: wr_all_n, gate_n: lane_gate_n};

  bwc_decode #(.LANES(LANES)) u_decode (
    .clk(clk), .rst(rst), .ctl(ctl), .pick_n(lane_pick_n),
    .strobe(lane_strobe), .drive_off(drive_off)
  );

  bwc_datain #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_datain (
    .clk(clk), .rst(rst), .addr_in(word_addr), .data_in(wr_data),
    .addr_q(addr_q), .data_q(data_q)
  );

  bwc_lane_mem #(.LANES(LANES), .LANE_W(LANE_W), .ADDR_W(ADDR_W)) u_mem (
    .clk(clk), .we(lane_strobe), .addr(addr_q), .wdata(data_q), .rdata(rd_data)
  );

  assert_reset_quiet_R1: assert property (@(posedge clk)
    $past(rst) |-> (lane_strobe == '0 && !drive_off));
endmodule

// File: tb/byte_write_ctrl_test.sv
module byte_write_ctrl_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_all_n = 1'b1, lane_gate_n = 1'b1, proc_start_n = 1'b1;
  logic [3:0]  lane_pick_n = 4'hF;
  logic [5:0]  word_addr = '0;
  logic [31:0] wr_data = '0;
  logic [3:0]  lane_strobe;
  logic        drive_off;
  logic [31:0] rd_data;

  int checks = 0, errors = 0;

  // reference state
  logic [7:0]  mm [64][4];
  bit          mk [64][4];
  logic [3:0]  e_we = '0;
  logic        e_dis = 1'b0;
  logic [5:0]  e_addr = '0;
  logic [31:0] e_din = '0;
  logic [31:0] e_rd = '0;
  logic [3:0]  e_rk = '0;

  byte_write_ctrl uut (
    .clk(clk), .rst(rst), .wr_all_n(wr_all_n), .lane_gate_n(lane_gate_n),
    .lane_pick_n(lane_pick_n), .proc_start_n(proc_start_n),
    .word_addr(word_addr), .wr_data(wr_data),
    .lane_strobe(lane_strobe), .drive_off(drive_off), .rd_data(rd_data)
  );

  always #10 clk = ~clk;

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #1000000;
    checks++; errors++;
    $display("FAIL watchdog expired act=running exp=done");
    finish_run();
  end

  task automatic model_edge();
    for (int l = 0; l < 4; l++) begin
      e_rk[l] = mk[e_addr][l];
      e_rd[l*8 +: 8] = mm[e_addr][l];
    end
    for (int l = 0; l < 4; l++)
      if (e_we[l]) begin mm[e_addr][l] = e_din[l*8 +: 8]; mk[e_addr][l] = 1'b1; end
    if (rst) begin
      e_we = '0; e_addr = '0; e_din = '0;
    end else begin
      if (!proc_start_n) e_we = 4'h0;
      else if (!wr_all_n) e_we = 4'hF;
      else if (!lane_gate_n) e_we = ~lane_pick_n;
      else e_we = 4'h0;
      e_addr = word_addr; e_din = wr_data;
    end
    e_dis = (e_we != 4'h0);
  endtask

  task automatic compare(string tag);
    checks++;
    if (lane_strobe !== e_we) begin
      errors++;
      $display("FAIL %s lane_strobe act=%h exp=%h", tag, lane_strobe, e_we);
    end
    checks++;
    if (drive_off !== e_dis) begin
      errors++;
      $display("FAIL R7 (%s) drive_off act=%b exp=%b", tag, drive_off, e_dis);
    end
    if (e_rk != 4'h0) begin
      checks++;
      for (int l = 0; l < 4; l++)
        if (e_rk[l] && rd_data[l*8 +: 8] !== e_rd[l*8 +: 8]) begin
          errors++;
          $display("FAIL R9 (%s) rd_data lane %0d act=%h exp=%h", tag, l,
                   rd_data[l*8 +: 8], e_rd[l*8 +: 8]);
          break;
        end
    end
  endtask

  task automatic cyc(input logic r, input logic p_n, input logic a_n,
                     input logic g_n, input logic [3:0] s_n,
                     input logic [5:0] ad, input logic [31:0] d, input string tag);
    @(negedge clk);
    rst = r; proc_start_n = p_n; wr_all_n = a_n; lane_gate_n = g_n;
    lane_pick_n = s_n; word_addr = ad; wr_data = d;
    @(posedge clk);
    model_edge();
    #2;
    compare(tag);
  endtask

  task automatic idle(input logic [5:0] ad, input string tag);
    cyc(1'b0, 1'b1, 1'b1, 1'b1, 4'hF, ad, 32'h0, tag);
  endtask

  initial begin
    for (int a = 0; a < 64; a++)
      for (int l = 0; l < 4; l++) begin mm[a][l] = '0; mk[a][l] = 1'b0; end

    // R1: reset holds strobes low even with a global write requested
    for (int i = 0; i < 3; i++)
      cyc(1'b1, 1'b1, 1'b0, 1'b0, 4'h0, 6'd0, 32'hFFFF_FFFF, "R1");

    // R2: global write on words 0..7, gate and selects varied
    for (int a = 0; a < 8; a++)
      cyc(1'b0, 1'b1, 1'b0, a[0], a[3:0] ^ 4'hA, 6'(a), 32'hA5000000 + 32'(a * 32'h01010101), "R2");
    for (int a = 0; a < 8; a++) idle(6'(a), "R2");
    idle(6'd0, "R2"); idle(6'd0, "R2");

    // R3/R5: every select mask, one word each, over a full-word base
    for (int m = 0; m < 16; m++)
      cyc(1'b0, 1'b1, 1'b0, 1'b1, 4'hF, 6'(16 + m), 32'h1111_1111 * 32'(m), "R3");
    for (int m = 0; m < 16; m++)
      cyc(1'b0, 1'b1, 1'b1, 1'b0, ~4'(m), 6'(16 + m), 32'hC3C3_C3C3 ^ 32'(m),
          (m == 0) ? "R5" : "R3");
    for (int m = 0; m < 16; m++) idle(6'(16 + m), "R3");
    idle(6'd0, "R3"); idle(6'd0, "R3");

    // R4: gate and global high, selects low: no write to word 3
    cyc(1'b0, 1'b1, 1'b1, 1'b1, 4'h0, 6'd3, 32'hDEAD_BEEF, "R4");
    idle(6'd3, "R4"); idle(6'd3, "R4"); idle(6'd3, "R4");

    // R6: processor strobe blocks a global and a gated write
    cyc(1'b0, 1'b0, 1'b0, 1'b0, 4'h0, 6'd4, 32'h0BAD_0BAD, "R6");
    cyc(1'b0, 1'b0, 1'b1, 1'b0, 4'h0, 6'd5, 32'h0BAD_0BAD, "R6");
    idle(6'd4, "R6"); idle(6'd5, "R6"); idle(6'd5, "R6");

    // R8/R10: back-to-back writes to changing addresses, then readback
    cyc(1'b0, 1'b1, 1'b0, 1'b1, 4'hF, 6'd40, 32'h4040_4040, "R10");
    cyc(1'b0, 1'b1, 1'b1, 1'b0, 4'hE, 6'd41, 32'h4141_4141, "R10");
    cyc(1'b0, 1'b1, 1'b0, 1'b1, 4'hF, 6'd42, 32'h4242_4242, "R10");
    cyc(1'b0, 1'b1, 1'b0, 1'b1, 4'hF, 6'd41, 32'h9999_0000, "R8");
    cyc(1'b0, 1'b1, 1'b1, 1'b0, 4'h5, 6'd40, 32'h7777_7777, "R8");
    for (int a = 40; a < 43; a++) idle(6'(a), "R8");
    idle(6'd40, "R8"); idle(6'd40, "R8");

    // R9: write then immediate read of the same word shows old data first
    cyc(1'b0, 1'b1, 1'b0, 1'b1, 4'hF, 6'd7, 32'h1234_5678, "R9");
    idle(6'd7, "R9"); idle(6'd7, "R9"); idle(6'd7, "R9");

    // R1 again: reset mid-run after a write request
    cyc(1'b0, 1'b1, 1'b0, 1'b1, 4'hF, 6'd9, 32'h5555_AAAA, "R2");
    cyc(1'b1, 1'b1, 1'b0, 1'b1, 4'hF, 6'd9, 32'h0, "R1");
    idle(6'd9, "R1"); idle(6'd9, "R1");

    finish_run();
  end
endmodule